// File: doc/BRIEF.md
# Boot Vector and Overlay Controller

This block decides where a processor starts fetching once reset is released, and it steers every later code fetch in the top 1 kB of the 64 kB program space either to an internal boot region or to ordinary user memory. On the clock edge where the active-low reset is first seen released, it looks at three things: a stored boot status byte, a stored boot vector byte, and a program-store-enable pin. If the status byte is nonzero, or if the pin is low on that edge, the block enters boot mode. The start address is then the vector in the high byte and zero in the low byte, and an ISP-mode flag is raised. In every other case execution begins at 0000H.

The boot overlay covers FC00H to FFFFH. It comes out of reset enabled exactly when boot entry was chosen. Software can later switch it on or off through a one-bit write port, so that a running program can reach the user code that lies under the boot region. The route for each fetch is decoded combinationally from the fetch address. A write changes the route from the following cycle onwards.

Top module: `boot_ovl_ctrl`

## Requirements
- R1: When the boot status byte is zero and the enable pin is high at the release edge, start_addr becomes 0000H and isp_mode stays 0.
- R2: When the boot status byte is nonzero at the release edge, start_addr becomes {boot_vec, 8'h00} and isp_mode becomes 1. For example, a vector of FCH gives FC00H.
- R3: A low level on psen_n at the release edge selects boot entry even when the status byte is zero. Later changes of psen_n have no effect until the next reset.
- R4: Only the level on psen_n at the first clock edge with rst_n high is used. Its level during the earlier reset cycles is ignored.
- R5: isp_mode is 1 exactly when the start address was taken from the vector. This includes a vector of 00H, which gives start_addr 0000H with isp_mode 1.
- R6: start_addr and isp_mode hold their values from the release edge until rst_n is next asserted, whatever boot_status and boot_vec do in the meantime.
- R7: While rst_n is low, start_addr reads 0000H, isp_mode reads 0, and fetch_boot reads 0 for every address.
- R8: After release, the overlay is enabled when boot entry was selected and disabled otherwise.
- R9: fetch_boot is 1 exactly when the overlay is enabled and fetch_addr[15:10] is all ones (FC00H to FFFFH). It follows fetch_addr in the same cycle.
- R10: A write (ovl_wr = 1) loads ovl_wr_val into the overlay enable at the clock edge. A fetch in the same cycle still uses the old setting, and fetches from the next cycle use the new one.
- R11: A write presented on the release edge is ignored, and the overlay takes the value given by R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psen_n | input | 1 | Program-store-enable pin; low at release forces boot entry |
| boot_status | input | 8 | Stored boot status byte; nonzero selects boot entry |
| boot_vec | input | 8 | Stored boot vector, used as the start address high byte |
| fetch_addr | input | 16 | Current code fetch address |
| ovl_wr | input | 1 | Software write strobe for the overlay enable |
| ovl_wr_val | input | 1 | Value written to the overlay enable |
| start_addr | output | 16 | First instruction address after reset |
| fetch_boot | output | 1 | 1 routes the fetch to boot memory, 0 to user memory |
| isp_mode | output | 1 | Set when the start address came from the boot vector |

## Verification
Two functions can act in the same cycle: a software write to the overlay enable and a fetch inside FC00H–FFFFH. The bench places a write that inverts the enable in the same cycle as a fetch from the overlay range. It expects the old route in that cycle and the new route in the following cycle. The release load of the enable can also meet a software write. For that case the bench drives a write of the opposite value on the release edge and expects the value chosen by the boot decision to survive. Random cycles mix writes and fetches, and each one is judged against a bench model of the enable.

// File: rtl/boot_ovl_pkg.sv
// Shared definitions for the boot vector and overlay controller.
// Assumes nothing beyond a single clock domain.
package boot_ovl_pkg;

    // Reset phase of the entry selector: held in reset, or running.
    typedef enum logic {
        PH_HELD = 1'b0,
        PH_RUN  = 1'b1
    } boot_phase_e;

    // Outcome of the boot entry decision taken at release.
    typedef struct packed {
        logic boot;   // start taken from vector
        logic force_; // pin forced entry
    } entry_dec_t;

endpackage

// File: rtl/boot_entry_sel.sv
// Boot entry selector.
// What it does: on the first clock edge with rst_n high after a reset, it decides between user
// start and boot start, then latches the start address and the ISP flag until the next reset.
// Assumes: rst_n is already synchronous to clk; boot_status and boot_vec are stable at release.
module boot_entry_sel
    import boot_ovl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VEC_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psen_n,
    input  logic [STAT_W-1:0] boot_status,
    input  logic [VEC_W-1:0]  boot_vec,
    output logic              load_now,
    output logic              entry_boot,
    output logic [ADDR_W-1:0] start_addr,
    output logic              isp_mode
);
    localparam int LOW_W = ADDR_W - VEC_W;

    boot_phase_e       phase_q;
    entry_dec_t        dec;
    logic [ADDR_W-1:0] start_q;
    logic              isp_q;

    // Purpose: tracks whether the block is still held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_HELD;
        else        phase_q <= PH_RUN;
    end

    // Purpose: forms the release strobe and the entry decision from status and pin.
    always_comb begin
        load_now    = rst_n && (phase_q == PH_HELD);
        dec.force_  = ~psen_n;
        dec.boot    = (|boot_status) | dec.force_;
        entry_boot  = dec.boot;
    end

    // Purpose: captures start address and ISP flag on the release edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            isp_q   <= 1'b0;
        end else if (load_now) begin
            start_q <= dec.boot ? {boot_vec, {LOW_W{1'b0}}} : '0;
            isp_q   <= dec.boot;
        end
    end

    assign start_addr = start_q;
    assign isp_mode   = isp_q;

endmodule

// File: rtl/ovl_enable_reg.sv
// Overlay enable register.
// What it does: holds the boot overlay enable. It is loaded from the entry decision on release
// and otherwise by software writes.
// Assumes: load_now is a single-cycle strobe, and it takes priority over a software write.
module ovl_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load_now,
    input  logic load_val,
    input  logic wr_en,
    input  logic wr_val,
    output logic ovl_en
);
    logic en_q;

    // Purpose: updates the enable, giving the release load priority over writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= 1'b0;
        else if (load_now) en_q <= load_val;
        else if (wr_en)    en_q <= wr_val;
    end

    assign ovl_en = en_q;

endmodule

// File: rtl/ovl_decode.sv
// Overlay address decoder.
// What it does: flags a fetch that falls in the top region of program space while the overlay
// is enabled.
// Assumes: the region is aligned and spans the top 2**(ADDR_W-OVL_BITS) addresses.
module ovl_decode #(
    parameter int ADDR_W   = 16,
    parameter int OVL_BITS = 6
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ovl_en,
    output logic              hit
);
    generate
        if (OVL_BITS == 0) begin : g_full
            // Purpose: the whole space is overlaid when no tag bits are compared.
            always_comb hit = ovl_en;
        end else begin : g_tag
            logic [OVL_BITS-1:0] tag;
            // Purpose: compares the upper address bits against all ones.
            always_comb begin
                tag = fetch_addr[ADDR_W-1 -: OVL_BITS];
                hit = ovl_en && (&tag);
            end
        end
    endgenerate

endmodule

// File: rtl/boot_ovl_ctrl.sv
// Boot vector and overlay controller, top level.
// What it does: picks the start address after reset and routes fetches in the top 1 kB to the
// boot region or to user memory.
// Assumes: rst_n is synchronous to clk and active low.
module boot_ovl_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int VEC_W    = 8,
    parameter int STAT_W   = 8,
    parameter int OVL_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psen_n,
    input  logic [STAT_W-1:0] boot_status,
    input  logic [VEC_W-1:0]  boot_vec,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ovl_wr,
    input  logic              ovl_wr_val,
    output logic [ADDR_W-1:0] start_addr,
    output logic              fetch_boot,
    output logic              isp_mode
);
    logic load_now;
    logic entry_boot;
    logic ovl_en;

    boot_entry_sel #(
        .ADDR_W (ADDR_W),
        .VEC_W  (VEC_W),
        .STAT_W (STAT_W)
    ) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .psen_n      (psen_n),
        .boot_status (boot_status),
        .boot_vec    (boot_vec),
        .load_now    (load_now),
        .entry_boot  (entry_boot),
        .start_addr  (start_addr),
        .isp_mode    (isp_mode)
    );

    ovl_enable_reg u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_now (load_now),
        .load_val (entry_boot),
        .wr_en    (ovl_wr),
        .wr_val   (ovl_wr_val),
        .ovl_en   (ovl_en)
    );

    ovl_decode #(
        .ADDR_W   (ADDR_W),
        .OVL_BITS (OVL_BITS)
    ) u_dec (
        .fetch_addr (fetch_addr),
        .ovl_en     (ovl_en),
        .hit        (fetch_boot)
    );

endmodule

// File: rtl/boot_ovl_chk.sv
// Assertion checker for boot_ovl_ctrl, attached with bind.
// What it does: checks the port-level timing rules of start selection and overlay routing.
// Assumes: the same clock and reset as the checked block.
module boot_ovl_chk #(
    parameter int ADDR_W   = 16,
    parameter int VEC_W    = 8,
    parameter int OVL_BITS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              ovl_wr,
    input logic              ovl_wr_val,
    input logic [ADDR_W-1:0] start_addr,
    input logic              fetch_boot,
    input logic              isp_mode
);
    localparam int LOW_W = ADDR_W - VEC_W;

    logic [1:0] run_cnt;

    // Purpose: counts the cycles since release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= 2'd0;
        else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
    end

    AST_START_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd2) |-> ($stable(start_addr) && $stable(isp_mode))); // R6

    AST_USER_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt != 2'd0) && !isp_mode) |-> (start_addr == '0)); // R1

    AST_BOOT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt != 2'd0) && isp_mode) |-> (start_addr[LOW_W-1:0] == '0)); // R2

    AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_boot |-> (&fetch_addr[ADDR_W-1 -: OVL_BITS])); // R9

    AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt != 2'd0) && ovl_wr) |=>
            (fetch_boot == ($past(ovl_wr_val) && (&fetch_addr[ADDR_W-1 -: OVL_BITS])))); // R10

    AST_HELD_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ((start_addr == '0) && !isp_mode && !fetch_boot)); // R7

endmodule

bind boot_ovl_ctrl boot_ovl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .OVL_BITS (OVL_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_addr (fetch_addr),
    .ovl_wr     (ovl_wr),
    .ovl_wr_val (ovl_wr_val),
    .start_addr (start_addr),
    .fetch_boot (fetch_boot),
    .isp_mode   (isp_mode)
);

// File: tb/tb_boot_ovl_ctrl.sv
`timescale 1ns/1ps
module tb_boot_ovl_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psen_n = 1'b1;
    logic [7:0]  boot_status = '0;
    logic [7:0]  boot_vec = '0;
    logic [15:0] fetch_addr = '0;
    logic        ovl_wr = 1'b0;
    logic        ovl_wr_val = 1'b0;
    logic [15:0] start_addr;
    logic        fetch_boot;
    logic        isp_mode;

    int errors = 0;
    int checks = 0;
    bit m_ovl;
    bit m_boot;
    logic [15:0] m_start;

    boot_ovl_ctrl dut (
        .clk(clk), .rst_n(rst_n), .psen_n(psen_n), .boot_status(boot_status),
        .boot_vec(boot_vec), .fetch_addr(fetch_addr), .ovl_wr(ovl_wr),
        .ovl_wr_val(ovl_wr_val), .start_addr(start_addr), .fetch_boot(fetch_boot),
        .isp_mode(isp_mode)
    );

    always #10 clk = ~clk;

    function automatic bit exp_boot(input logic [7:0] st, input logic pin_n);
        return (st != 8'h00) || !pin_n;
    endfunction

    function automatic logic [15:0] exp_start(input bit b, input logic [7:0] v);
        return b ? {v, 8'h00} : 16'h0000;
    endfunction

    function automatic bit exp_hit(input bit en, input logic [15:0] a);
        return en && (a[15:10] == 6'b111111);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reset with given stored values and release-edge pin level; optional write on release edge.
    task automatic reset_seq(input logic [7:0] st, input logic [7:0] v, input logic pin_rel,
                             input bit wr_at_rel);
        @(negedge clk);
        rst_n = 1'b0; ovl_wr = 1'b0; psen_n = ~pin_rel;
        boot_status = st; boot_vec = v; fetch_addr = 16'hFFFF;
        repeat (3) @(negedge clk);
        #2;
        chk(start_addr == 16'h0 && !isp_mode, "R7 held outputs", {start_addr, 7'b0, isp_mode}, 0);
        chk(!fetch_boot, "R7 held fetch_boot", fetch_boot, 0);
        @(negedge clk);
        rst_n = 1'b1; psen_n = pin_rel;
        m_boot = exp_boot(st, pin_rel);
        m_start = exp_start(m_boot, v);
        if (wr_at_rel) begin ovl_wr = 1'b1; ovl_wr_val = ~m_boot; end
        @(negedge clk);
        ovl_wr = 1'b0;
        psen_n = pin_rel;  // hold then flip later
        m_ovl = m_boot;
        #2;
        chk(start_addr == m_start, "R1 R2 R3 R4 start_addr", start_addr, m_start);
        chk(isp_mode == m_boot, "R5 isp_mode", isp_mode, m_boot);
        chk(fetch_boot == m_boot, wr_at_rel ? "R11 write at release" : "R8 overlay after reset",
            fetch_boot, m_boot);
        psen_n = ~pin_rel;
        @(negedge clk); #2;
        chk(start_addr == m_start && isp_mode == m_boot, "R3 pin change after release",
            start_addr, m_start);
    endtask

    // Random run cycles with writes, fetches and stored-value changes.
    task automatic run_random(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_addr = ($urandom % 2) ? (16'hFC00 | 16'($urandom % 1024)) : 16'($urandom);
            ovl_wr = (($urandom % 4) == 0);
            ovl_wr_val = 1'($urandom);
            boot_status = 8'($urandom);
            boot_vec = 8'($urandom);
            psen_n = 1'($urandom);
            #2;
            chk(fetch_boot == exp_hit(m_ovl, fetch_addr), "R9 R10 fetch route",
                fetch_boot, exp_hit(m_ovl, fetch_addr));
            chk(start_addr == m_start && isp_mode == m_boot, "R6 start held",
                start_addr, m_start);
            if (ovl_wr) m_ovl = ovl_wr_val;
        end
        @(negedge clk);
        ovl_wr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: user start
        reset_seq(8'h00, 8'hFC, 1'b1, 1'b0);
        // R9: boundary addresses with overlay off then on
        @(negedge clk); fetch_addr = 16'hFC00; #2;
        chk(!fetch_boot, "R9 FC00 overlay off", fetch_boot, 0);
        @(negedge clk); ovl_wr = 1'b1; ovl_wr_val = 1'b1; fetch_addr = 16'hFC00; #2;
        chk(!fetch_boot, "R10 same-cycle old value", fetch_boot, 0);
        @(negedge clk); ovl_wr = 1'b0; #2;
        chk(fetch_boot, "R10 next-cycle new value", fetch_boot, 1);
        fetch_addr = 16'hFBFF; #1;
        chk(!fetch_boot, "R9 FBFF below region", fetch_boot, 0);
        fetch_addr = 16'hFFFF; #1;
        chk(fetch_boot, "R9 FFFF top", fetch_boot, 1);
        m_ovl = 1'b1;
        // R2: default vector FC gives FC00
        reset_seq(8'h01, 8'hFC, 1'b1, 1'b0);
        chk(start_addr == 16'hFC00, "R2 default vector entry", start_addr, 16'hFC00);
        // R10: disable on the fly, same cycle as a top fetch
        @(negedge clk); fetch_addr = 16'hFE12; ovl_wr = 1'b1; ovl_wr_val = 1'b0; #2;
        chk(fetch_boot, "R10 disable same cycle", fetch_boot, 1);
        @(negedge clk); ovl_wr = 1'b0; #2;
        chk(!fetch_boot, "R10 disabled next cycle", fetch_boot, 0);
        // R3: pin forces boot with zero status
        reset_seq(8'h00, 8'h80, 1'b0, 1'b0);
        // R5: vector 00 with boot
        reset_seq(8'hA5, 8'h00, 1'b1, 1'b0);
        chk(start_addr == 16'h0000 && isp_mode, "R5 vector zero boot", {start_addr, 7'b0, isp_mode}, 1);
        // R11: write on release edge, both polarities
        reset_seq(8'h00, 8'h12, 1'b1, 1'b1);
        reset_seq(8'h40, 8'h34, 1'b1, 1'b1);
        // Random resets and runs
        for (int k = 0; k < 40; k++) begin
            reset_seq(($urandom % 2) ? 8'h00 : 8'($urandom), 8'($urandom), 1'($urandom),
                      (($urandom % 4) == 0));
            run_random(30);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule